// File: doc/BRIEF.md
# Parallel Dual-Op Register Write Merger

This block is the register-file write stage of a 16-bit DSP core in which one instruction word may carry a main operation together with an attached extension operation. The two halves run side by side. Both read the same pre-instruction snapshot of the register file, and their write requests are committed together at one clock edge. The block also splits the instruction word into its main and extension opcode fields. Whether an extension field exists, and how wide it is, depends on the top nybble of the word.

The main half presents at most one write request per instruction. The extension half presents a list of up to `NEXT` pending writes, each with its own valid bit. A register named by only one half takes that half's value. A register named by both halves is resolved according to a mode input. In precise mode the two values are combined by bitwise OR. In the other mode the extension value replaces the main result. The extension half can never alter the program-counter slot, which is the highest register index.

Top module: `dual_write_merge`

## Requirements
- R1: When the top nybble `instr[15:12]` is 0, 1 or 2, `ext_present` is 0, `main_opc` equals the full 16-bit word and `ext_opc` is 0.
- R2: When the top nybble is 3, `ext_present` is 1, `main_opc` is `instr[15:7]` zero-extended to 16 bits, and `ext_opc` is `{1'b0, instr[6:0]}`.
- R3: When the top nybble is 4 or above, `ext_present` is 1, `main_opc` is `instr[15:8]` zero-extended to 16 bits, and `ext_opc` is `instr[7:0]`.
- R4: While `ext_present` is 0, extension write entries are discarded and do not affect any register.
- R5: On an issue cycle, a register written by only one half takes exactly that half's value, and every register written by neither half keeps its value.
- R6: With `precise` = 1, a register written by both halves takes the bitwise OR of the main value and the extension value.
- R7: With `precise` = 0, a register written by both halves takes the extension value.
- R8: Extension entries that target index `NREG-1` (the program counter) are dropped. A main write to that index is applied.
- R9: Several valid extension entries that target the same register are combined by bitwise OR before they are merged with the main value.
- R10: All writes of one instruction commit at the same rising edge. During the issue cycle, `rd_data` returns the pre-instruction value, so opposite moves between two registers swap their contents.
- R11: When `issue` is 0, no register changes, whatever write requests are present.
- R12: A synchronous active-high `rst` clears every register to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue | input | 1 | Commits this cycle's merged writes at the next edge |
| instr | input | 16 | Instruction word to split |
| precise | input | 1 | 1: OR-merge on collision; 0: extension value wins |
| main_we | input | 1 | Main half write request |
| main_idx | input | 5 | Main write register index |
| main_val | input | 16 | Main write value |
| ext_we | input | 4 | Valid bit per extension entry |
| ext_idx | input | 20 | Packed extension indices, entry e at bits [5e+4:5e] |
| ext_val | input | 64 | Packed extension values, entry e at bits [16e+15:16e] |
| rd_idx | input | 5 | Read port index |
| rd_data | output | 16 | Current register value (combinational) |
| main_opc | output | 16 | Decoded main opcode field |
| ext_opc | output | 8 | Decoded extension opcode field |
| ext_present | output | 1 | Word carries an extension field |

## Verification
The decoder is driven with words from each nybble class, including the class boundaries at 2/3 and 3/4. These patterns separate the full-word, 9/7-bit and 8/8-bit splits, and a bit-6/bit-7 pattern exposes any failure to force the top extension bit to zero. The merge logic is tried with main-only, extension-only, colliding writes under each mode, several extension entries hitting one register, a program-counter target, and a non-extendable word that carries extension entries. Each pattern uses distinct bit groups, so OR, overwrite and drop give different results. A register swap and a read during the issue cycle tell a snapshot commit apart from one that updates in sequence, and an idle cycle with live requests checks the issue gate.

// File: rtl/regmerge_pkg.sv
package regmerge_pkg;

  localparam int INSTR_W = 16;

  // Resolve one register's next value from the two halves' requests.
  function automatic logic [15:0] merge_word(
    input logic        precise,
    input logic        main_hit,
    input logic        ext_hit,
    input logic [15:0] main_v,
    input logic [15:0] ext_v,
    input logic [15:0] cur_v
  );
    logic [15:0] res;
    if (main_hit && ext_hit)
      res = precise ? (main_v | ext_v) : ext_v;
    else if (main_hit)
      res = main_v;
    else if (ext_hit)
      res = ext_v;
    else
      res = cur_v;
    return res;
  endfunction

endpackage

// File: rtl/dualop_split.sv
module dualop_split
  import regmerge_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output logic [INSTR_W-1:0] main_opc,
  output logic [7:0]         ext_opc,
  output logic               ext_present
);

  logic [3:0] top_nyb;
  assign top_nyb = instr[15:12];

  always_comb begin
    if (top_nyb < 4'd3) begin
      ext_present = 1'b0;
      main_opc    = instr;
      ext_opc     = 8'h00;
    end else if (top_nyb == 4'd3) begin
      ext_present = 1'b1;
      main_opc    = {7'b0, instr[15:7]};
      ext_opc     = {1'b0, instr[6:0]};
    end else begin
      ext_present = 1'b1;
      main_opc    = {8'b0, instr[15:8]};
      ext_opc     = instr[7:0];
    end
  end

endmodule

// File: rtl/ext_gather.sv
module ext_gather #(
  parameter int NREG = 32,
  parameter int NEXT = 4,
  parameter int W    = 16,
  localparam int IDXW   = $clog2(NREG),
  localparam int PC_IDX = NREG - 1
) (
  input  logic              allow,
  input  logic [NEXT-1:0]   ext_we,
  input  logic [NEXT*IDXW-1:0] ext_idx,
  input  logic [NEXT*W-1:0] ext_val,
  output logic [NREG-1:0]   hit_vec,
  output logic [NREG*W-1:0] or_flat
);

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    logic         h;
    logic [W-1:0] acc;
    always_comb begin
      h   = 1'b0;
      acc = '0;
      for (int e = 0; e < NEXT; e++) begin
        if (allow && ext_we[e] && (r != PC_IDX) &&
            (ext_idx[e*IDXW +: IDXW] == IDXW'(r))) begin
          h   = 1'b1;
          acc = acc | ext_val[e*W +: W];
        end
      end
    end
    assign hit_vec[r]         = h;
    assign or_flat[r*W +: W]  = acc;
  end

endmodule

// File: rtl/merge_bank.sv
module merge_bank
  import regmerge_pkg::*;
#(
  parameter int NREG = 32,
  parameter int W    = 16,
  localparam int IDXW = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              commit,
  input  logic              precise,
  input  logic              main_we,
  input  logic [IDXW-1:0]   main_idx,
  input  logic [W-1:0]      main_val,
  input  logic [NREG-1:0]   ext_hit_vec,
  input  logic [NREG*W-1:0] ext_or_flat,
  input  logic [IDXW-1:0]   rd_idx,
  output logic [W-1:0]      rd_data,
  output logic [NREG*W-1:0] reg_flat
);

  logic [W-1:0] rf     [NREG];
  logic [W-1:0] rf_nxt [NREG];

  for (genvar r = 0; r < NREG; r++) begin : g_nxt
    logic mh;
    assign mh        = main_we && (main_idx == IDXW'(r));
    assign rf_nxt[r] = merge_word(precise, mh, ext_hit_vec[r], main_val,
                                  ext_or_flat[r*W +: W], rf[r]);
    assign reg_flat[r*W +: W] = rf[r];
  end

  always_ff @(posedge clk) begin
    for (int r = 0; r < NREG; r++) begin
      if (rst)         rf[r] <= '0;
      else if (commit) rf[r] <= rf_nxt[r];
    end
  end

  assign rd_data = rf[rd_idx];

endmodule

// File: rtl/dual_write_merge.sv
module dual_write_merge
  import regmerge_pkg::*;
#(
  parameter int NREG = 32,
  parameter int NEXT = 4,
  parameter int W    = 16,
  localparam int IDXW = $clog2(NREG)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 issue,
  input  logic [INSTR_W-1:0]   instr,
  input  logic                 precise,
  input  logic                 main_we,
  input  logic [IDXW-1:0]      main_idx,
  input  logic [W-1:0]         main_val,
  input  logic [NEXT-1:0]      ext_we,
  input  logic [NEXT*IDXW-1:0] ext_idx,
  input  logic [NEXT*W-1:0]    ext_val,
  input  logic [IDXW-1:0]      rd_idx,
  output logic [W-1:0]         rd_data,
  output logic [INSTR_W-1:0]   main_opc,
  output logic [7:0]           ext_opc,
  output logic                 ext_present
);

  // Named internal events, visible to the bound checker.
  logic [NREG-1:0]   ext_hit_vec;
  logic [NREG*W-1:0] ext_or_flat;
  logic [NREG*W-1:0] reg_flat;

  dualop_split u_split (
    .instr       (instr),
    .main_opc    (main_opc),
    .ext_opc     (ext_opc),
    .ext_present (ext_present)
  );

  ext_gather #(.NREG(NREG), .NEXT(NEXT), .W(W)) u_gather (
    .allow   (ext_present),
    .ext_we  (ext_we),
    .ext_idx (ext_idx),
    .ext_val (ext_val),
    .hit_vec (ext_hit_vec),
    .or_flat (ext_or_flat)
  );

  merge_bank #(.NREG(NREG), .W(W)) u_bank (
    .clk         (clk),
    .rst         (rst),
    .commit      (issue),
    .precise     (precise),
    .main_we     (main_we),
    .main_idx    (main_idx),
    .main_val    (main_val),
    .ext_hit_vec (ext_hit_vec),
    .ext_or_flat (ext_or_flat),
    .rd_idx      (rd_idx),
    .rd_data     (rd_data),
    .reg_flat    (reg_flat)
  );

endmodule

// File: rtl/dual_write_merge_chk.sv
module dual_write_merge_chk #(
  parameter int NREG = 32,
  parameter int W    = 16,
  localparam int IDXW   = $clog2(NREG),
  localparam int PC_IDX = NREG - 1
) (
  input logic              clk,
  input logic              rst,
  input logic              issue,
  input logic              precise,
  input logic              main_we,
  input logic [IDXW-1:0]   main_idx,
  input logic [W-1:0]      main_val,
  input logic              ext_present,
  input logic [NREG-1:0]   ext_hit_vec,
  input logic [NREG*W-1:0] ext_or_flat,
  input logic [NREG*W-1:0] reg_flat
);

  AST_EXT_GATED: assert property (@(posedge clk) disable iff (rst)
    !ext_present |-> ext_hit_vec == '0);  // R4

  AST_MAIN_ALONE: assert property (@(posedge clk) disable iff (rst)
    issue && main_we && !ext_hit_vec[main_idx]
      |=> reg_flat[$past(main_idx)*W +: W] == $past(main_val));  // R5

  AST_OR_MERGE: assert property (@(posedge clk) disable iff (rst)
    issue && precise && main_we && ext_hit_vec[main_idx]
      |=> reg_flat[$past(main_idx)*W +: W] ==
          ($past(main_val) | $past(ext_or_flat[main_idx*W +: W])));  // R6

  AST_EXT_WINS: assert property (@(posedge clk) disable iff (rst)
    issue && !precise && main_we && ext_hit_vec[main_idx]
      |=> reg_flat[$past(main_idx)*W +: W] ==
          $past(ext_or_flat[main_idx*W +: W]));  // R7

  AST_PC_KEPT: assert property (@(posedge clk) disable iff (rst)
    issue && !(main_we && main_idx == IDXW'(PC_IDX))
      |=> $stable(reg_flat[PC_IDX*W +: W]));  // R8

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !issue |=> $stable(reg_flat));  // R11

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> reg_flat == '0);  // R12

endmodule

bind dual_write_merge dual_write_merge_chk #(.NREG(NREG), .W(W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .issue       (issue),
  .precise     (precise),
  .main_we     (main_we),
  .main_idx    (main_idx),
  .main_val    (main_val),
  .ext_present (ext_present),
  .ext_hit_vec (ext_hit_vec),
  .ext_or_flat (ext_or_flat),
  .reg_flat    (reg_flat)
);

// File: tb/dual_write_merge_test.sv
module dual_write_merge_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        issue = 1'b0;
  logic [15:0] instr = 16'h0000;
  logic        precise = 1'b1;
  logic        main_we = 1'b0;
  logic [4:0]  main_idx = '0;
  logic [15:0] main_val = '0;
  logic [3:0]  ext_we = '0;
  logic [19:0] ext_idx = '0;
  logic [63:0] ext_val = '0;
  logic [4:0]  rd_idx = '0;
  logic [15:0] rd_data, main_opc;
  logic [7:0]  ext_opc;
  logic        ext_present;

  int n_run = 0, n_fail = 0, cyc = 0;

  typedef struct { int idx; logic [15:0] exp; string tag; } item_t;
  item_t sbq[$];

  always #2 clk = ~clk;

  dual_write_merge uut (
    .clk(clk), .rst(rst), .issue(issue), .instr(instr), .precise(precise),
    .main_we(main_we), .main_idx(main_idx), .main_val(main_val),
    .ext_we(ext_we), .ext_idx(ext_idx), .ext_val(ext_val),
    .rd_idx(rd_idx), .rd_data(rd_data), .main_opc(main_opc),
    .ext_opc(ext_opc), .ext_present(ext_present)
  );

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_run++; n_fail++;
      $display("FAIL R10 watchdog: actual=hung expected=done");
      finish_run();
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver side: expected register contents go into the scoreboard.
  task automatic expect_reg(int idx, logic [15:0] v, string tag);
    item_t it;
    it.idx = idx; it.exp = v; it.tag = tag;
    sbq.push_back(it);
  endtask

  // Monitor side: read each expected register through the read port.
  task automatic drain();
    while (sbq.size() > 0) begin
      item_t it;
      it = sbq.pop_front();
      @(negedge clk);
      rd_idx = it.idx[4:0];
      #1 check(it.tag, {16'h0, rd_data}, {16'h0, it.exp});
    end
  endtask

  task automatic set_ext(int e, int idx, logic [15:0] v);
    ext_we[e] = 1'b1;
    ext_idx[e*5 +: 5] = idx[4:0];
    ext_val[e*16 +: 16] = v;
  endtask

  task automatic clear_req();
    issue = 1'b0; main_we = 1'b0; ext_we = '0; ext_idx = '0; ext_val = '0;
  endtask

  // Drive one instruction at a falling edge; it commits at the next rise.
  task automatic fire(logic [15:0] w, logic p);
    instr = w; precise = p; issue = 1'b1;
    @(posedge clk);
    @(negedge clk);
    clear_req();
  endtask

  task automatic main_req(int idx, logic [15:0] v);
    main_we = 1'b1; main_idx = idx[4:0]; main_val = v;
  endtask

  task automatic check_decode(logic [15:0] w);
    logic [15:0] em; logic [7:0] ee; logic ep;
    instr = w;
    if (w[15:12] <= 4'd2)      begin ep = 0; em = w;                ee = 0;                 end
    else if (w[15:12] == 4'd3) begin ep = 1; em = 16'(w >> 7);      ee = 8'(w & 16'h007F);  end
    else                       begin ep = 1; em = 16'(w >> 8);      ee = 8'(w & 16'h00FF);  end
    #1;
    check(w[15:12] <= 2 ? "R1 present" : (w[15:12] == 3 ? "R2 present" : "R3 present"),
          {31'h0, ext_present}, {31'h0, ep});
    check(w[15:12] <= 2 ? "R1 main" : (w[15:12] == 3 ? "R2 main" : "R3 main"),
          {16'h0, main_opc}, {16'h0, em});
    check(w[15:12] <= 2 ? "R1 ext" : (w[15:12] == 3 ? "R2 ext" : "R3 ext"),
          {24'h0, ext_opc}, {24'h0, ee});
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R12: reset state
    for (int r = 0; r < 32; r += 7) expect_reg(r, 16'h0000, "R12 reset");
    drain();

    // R1 / R2 / R3 decode classes and boundaries
    @(negedge clk);
    check_decode(16'h1234);
    check_decode(16'h2FFF);
    check_decode(16'h37C0);
    check_decode(16'h3F7F);
    check_decode(16'h4000);
    check_decode(16'h7660);
    check_decode(16'hFFAB);

    // R5: main only, then extension only
    @(negedge clk);
    main_req(1, 16'h1111); fire(16'h4000, 1'b1);
    set_ext(0, 2, 16'h00F0); fire(16'h8000, 1'b1);
    expect_reg(1, 16'h1111, "R5 main-only");
    expect_reg(2, 16'h00F0, "R5 ext-only");
    expect_reg(3, 16'h0000, "R5 untouched");
    drain();

    // R6: precise collision ORs
    @(negedge clk);
    main_req(3, 16'h1200); set_ext(1, 3, 16'h0034); fire(16'h7660, 1'b1);
    expect_reg(3, 16'h1234, "R6 or-merge");
    drain();

    // R7: non-precise collision, extension wins
    @(negedge clk);
    main_req(4, 16'hAAAA); set_ext(0, 4, 16'h5500); fire(16'h6113, 1'b0);
    expect_reg(4, 16'h5500, "R7 ext-wins");
    drain();

    // R4: non-extendable word drops extension entries
    @(negedge clk);
    main_req(6, 16'h0006); set_ext(0, 5, 16'hFFFF); set_ext(3, 6, 16'hF000);
    fire(16'h1000, 1'b1);
    expect_reg(5, 16'h0000, "R4 ext dropped");
    expect_reg(6, 16'h0006, "R4 main only kept");
    drain();

    // R8: extension cannot touch PC, main can
    @(negedge clk);
    set_ext(2, 31, 16'hBEEF); fire(16'h8800, 1'b1);
    expect_reg(31, 16'h0000, "R8 pc ext dropped");
    drain();
    @(negedge clk);
    main_req(31, 16'h0100); set_ext(0, 31, 16'h0002); fire(16'h8800, 1'b1);
    expect_reg(31, 16'h0100, "R8 pc main write");
    drain();

    // R9: several extension entries to one register
    @(negedge clk);
    set_ext(0, 7, 16'h00F0); set_ext(2, 7, 16'h0F00); set_ext(3, 7, 16'h8000);
    set_ext(1, 12, 16'h0001);
    fire(16'h3001, 1'b0);
    expect_reg(7, 16'h8FF0, "R9 ext or");
    expect_reg(12, 16'h0001, "R9 other entry");
    drain();

    // R10: snapshot swap
    @(negedge clk);
    main_req(8, 16'h1111); set_ext(0, 9, 16'h2222); fire(16'h5000, 1'b1);
    main_req(8, 16'h2222); set_ext(0, 9, 16'h1111);
    instr = 16'h6113; precise = 1'b1; issue = 1'b1; rd_idx = 5'd8;
    #1 check("R10 read old during issue", {16'h0, rd_data}, 32'h1111);
    @(posedge clk); @(negedge clk); clear_req();
    expect_reg(8, 16'h2222, "R10 swap a");
    expect_reg(9, 16'h1111, "R10 swap b");
    drain();

    // R11: requests without issue change nothing
    @(negedge clk);
    main_we = 1'b1; main_idx = 5'd10; main_val = 16'hDEAD; set_ext(0, 11, 16'hCAFE);
    instr = 16'h4000; repeat (2) @(posedge clk);
    @(negedge clk); clear_req();
    expect_reg(10, 16'h0000, "R11 idle main");
    expect_reg(11, 16'h0000, "R11 idle ext");
    drain();

    // R12: reset mid-run
    @(negedge clk); rst = 1'b1; @(posedge clk); @(negedge clk); rst = 1'b0;
    expect_reg(1, 16'h0000, "R12 clear r1");
    expect_reg(31, 16'h0000, "R12 clear pc");
    drain();

    finish_run();
  end

endmodule